// File: doc/BRIEF.md
# Four-Bit ALU with Operand Conditioning

This block is a purely combinational arithmetic and logic unit for 4-bit data. It has two stages in a chain. The first stage conditions one operand. It either leaves the operand as it is, flips every bit, or negates it arithmetically. The second stage combines the conditioned value with the accumulator value. It produces a bitwise AND or a binary sum, or it forwards the conditioned value unchanged.

Each stage is steered by its own pair of control bits. In the first stage, the invert bit decides whether the negate bit has any effect. In the second stage, the pass bit takes priority over the add bit. Chaining the stages gives composite operations: with invert, negate and add all set, the result is the accumulator minus the operand, modulo 16. The data width is a parameter with a default of 4.

There are no registers in the block. The result and the carry follow the inputs within the same cycle.

Top module: `nib_alu`

## Requirements
- R1: Every data path is WIDTH bits wide (default 4). The outputs are a purely combinational function of the current inputs. With all inputs at zero, both `result` and `carry_out` are 0.
- R2: When `inv_en`=0, the conditioned operand equals `opnd_a`, whatever the value of `neg_en`.
- R3: When `inv_en`=1 and `neg_en`=0, the conditioned operand is the bitwise inverse of `opnd_a`.
- R4: When `inv_en`=1 and `neg_en`=1, the conditioned operand is (~`opnd_a` + 1) mod 16. An operand of 0 gives 0, and an operand of 8 gives 8.
- R5: When `pass_en`=0 and `add_en`=0, `result` is the bitwise AND of the conditioned operand and `acc_b`.
- R6: When `pass_en`=0 and `add_en`=1, `result` is (conditioned operand + `acc_b`) mod 16.
- R7: In the sum mode, `carry_out` is bit 4 of the unclipped sum. In the AND mode and the forward mode, `carry_out` is 0.
- R8: When `pass_en`=1, `result` is the conditioned operand, whatever the value of `add_en`.
- R9: With `inv_en`, `neg_en` and `add_en` all at 1 and `pass_en`=0, `result` equals (`acc_b` − `opnd_a`) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 4 | Operand fed to the conditioning stage |
| acc_b | input | 4 | Accumulator value fed to the combine stage |
| inv_en | input | 1 | Enables conditioning: inversion, or negation together with neg_en |
| neg_en | input | 1 | Selects negation instead of inversion while inv_en is 1 |
| pass_en | input | 1 | Forwards the conditioned operand; overrides add_en |
| add_en | input | 1 | Selects the sum instead of the AND while pass_en is 0 |
| result | output | 4 | Combine-stage result |
| carry_out | output | 1 | Bit 4 of the sum; 0 in the other modes |

## Verification
There are no registers on any path, so both `result` and `carry_out` are due in the same cycle the inputs are applied. The bench changes the inputs on a rising clock edge and reads the outputs at the following falling edge, half a period later. By then the combinational logic has settled, and no clock-edge race can affect the sample. The bench sweeps every combination of operand, accumulator and the four control bits, and it computes the expected value arithmetically for each one.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  typedef enum logic [1:0] {
    CMB_AND  = 2'd0,
    CMB_SUM  = 2'd1,
    CMB_FWD  = 2'd2
  } cmb_mode_e;

  typedef enum logic [1:0] {
    CND_KEEP = 2'd0,
    CND_FLIP = 2'd1,
    CND_NEG  = 2'd2
  } cnd_mode_e;
endpackage

// File: rtl/nib_cond_stage.sv
module nib_cond_stage
  import nib_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             inv_i,
  input  logic             neg_i,
  output logic [WIDTH-1:0] cond_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  cnd_mode_e mode;

  always_comb begin
    if (!inv_i)     mode = CND_KEEP;
    else if (neg_i) mode = CND_NEG;
    else            mode = CND_FLIP;
  end

  always_comb begin
    case (mode)
      CND_FLIP: cond_o = ~opnd_i;
      CND_NEG:  cond_o = ~opnd_i + ONE;
      default:  cond_o = opnd_i;
    endcase
  end

  always_comb begin
    if (!inv_i) p_keep_r2: assert (cond_o == opnd_i);
    if (inv_i && !neg_i) p_flip_r3: assert ((cond_o ^ opnd_i) == {WIDTH{1'b1}});
    if (inv_i && neg_i) p_neg_r4: assert (WIDTH'(cond_o + opnd_i) == '0);
  end
endmodule

// File: rtl/nib_combine_stage.sv
module nib_combine_stage
  import nib_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cond_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic             pass_i,
  input  logic             add_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cry_o
);
  localparam int SUMW = WIDTH + 1;

  cmb_mode_e       mode;
  logic [SUMW-1:0] sum_w;

  always_comb begin
    if (pass_i)     mode = CMB_FWD;
    else if (add_i) mode = CMB_SUM;
    else            mode = CMB_AND;
  end

  assign sum_w = {1'b0, cond_i} + {1'b0, acc_i};

  always_comb begin
    case (mode)
      CMB_SUM: begin
        res_o = sum_w[WIDTH-1:0];
        cry_o = sum_w[WIDTH];
      end
      CMB_FWD: begin
        res_o = cond_i;
        cry_o = 1'b0;
      end
      default: begin
        res_o = cond_i & acc_i;
        cry_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (!pass_i && !add_i) p_and_subset_r5: assert ((res_o & ~cond_i) == '0 && (res_o & ~acc_i) == '0);
    if (!pass_i && add_i) p_sum_r6: assert (WIDTH'(res_o - acc_i) == cond_i);
    if (pass_i || !add_i) p_nocarry_r7: assert (cry_o == 1'b0);
    if (pass_i) p_fwd_r8: assert (res_o == cond_i);
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] acc_b,
  input  logic             inv_en,
  input  logic             neg_en,
  input  logic             pass_en,
  input  logic             add_en,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic [WIDTH-1:0] cond_w;

  nib_cond_stage #(.WIDTH(WIDTH)) cond_i (
    .opnd_i (opnd_a),
    .inv_i  (inv_en),
    .neg_i  (neg_en),
    .cond_o (cond_w)
  );

  nib_combine_stage #(.WIDTH(WIDTH)) comb_i (
    .cond_i (cond_w),
    .acc_i  (acc_b),
    .pass_i (pass_en),
    .add_i  (add_en),
    .res_o  (result),
    .cry_o  (carry_out)
  );

  always_comb begin
    if (inv_en && neg_en && add_en && !pass_en)
      p_subtract_r9: assert (WIDTH'(result + opnd_a) == acc_b);
  end
endmodule

// File: tb/nib_alu_tb_top.sv
module nib_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opnd_a = '0;
  logic [3:0] acc_b = '0;
  logic       inv_en = 1'b0, neg_en = 1'b0, pass_en = 1'b0, add_en = 1'b0;
  logic [3:0] result;
  logic       carry_out;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  nib_alu #(.WIDTH(4)) dut_i (
    .opnd_a(opnd_a), .acc_b(acc_b), .inv_en(inv_en), .neg_en(neg_en),
    .pass_en(pass_en), .add_en(add_en), .result(result), .carry_out(carry_out)
  );

  task automatic check(input string tag, input int exp_r, input int exp_c);
    n_vec++;
    if (int'(result) != exp_r || int'(carry_out) != exp_c) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d ctl=%b%b%b%b got r=%0d c=%0d exp r=%0d c=%0d",
               tag, opnd_a, acc_b, inv_en, neg_en, pass_en, add_en,
               result, carry_out, exp_r, exp_c);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 all-zero", 0, 0);
    for (int ctl = 0; ctl < 16; ctl++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int cnd, er, ec, raw;
          string tag;
          @(posedge clk);
          {inv_en, neg_en, pass_en, add_en} = 4'(ctl);
          opnd_a = 4'(a);
          acc_b  = 4'(b);
          if (!inv_en)     cnd = a;
          else if (neg_en) cnd = (16 - a) % 16;
          else             cnd = 15 - a;
          ec = 0;
          if (pass_en) begin
            er = cnd; tag = "R8 forward";
          end else if (add_en) begin
            raw = cnd + b; er = raw % 16; ec = raw / 16;
            tag = (inv_en && neg_en) ? "R9 subtract" : "R6/R7 sum";
          end else begin
            er = cnd & b; tag = "R5 and";
          end
          if (pass_en) begin
            if (!inv_en) tag = "R2 keep";
            else if (!neg_en) tag = "R3 flip";
            else tag = "R4 negate";
          end
          @(negedge clk);
          check(tag, er, ec);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule